// File: doc/BRIEF.md
# Scan Channel Sequencer with Clamp Control

This block is the digital timing core of a three-colour line-sensor front end that shares one converter among a red, a green and a blue input. It runs in the converter clock domain. It brings the black-level strobe, the video strobe and the line-clamp strobe into that domain through synchronisers. From these strobes and from configuration fields held in an external register block, it drives three things: the index of the colour the shared converter digitises next, the internal clamp enable of the input stage, and a flag that marks the converter result as usable.

In round-robin mode the index steps through the three colours on every clock. Each falling edge of the video strobe realigns the sequence so that green is selected right after it. In single-colour mode the index stays on one colour and the video strobe has no effect. When the block returns to round-robin mode it stays idle until a video-strobe falling edge resynchronises it. The first conversion after any synchronisation is marked invalid. A two-bit field chooses the clamp source. The block also passes on the alternate video-strobe timing request, but only where that request is allowed.

Top module: `scan_seq_top`

## Requirements
- R1: While running in round-robin mode (colour field 00) with no video-strobe falling edge in play, `chan_idx` advances by one position on every rising clock edge in the order red (0), green (1), blue (2), and then back to red.
- R2: In round-robin mode, a falling edge of `vid_strobe` forces `chan_idx` to green (1) on the third rising clock edge after the edge, whatever the current position is. The sequence then continues with blue. The three-edge latency comes from two synchroniser stages plus the index register.
- R3: With the colour field at 01 (red), 10 (green) or 11 (blue), `chan_idx` stays at 0, 1 or 2 respectively, and `vid_strobe` edges have no effect on it.
- R4: After the colour field changes to a single colour, `chan_idx` shows that colour on the second rising clock edge (field capture, then tracking).
- R5: After the colour field changes from a single colour back to 00, `data_valid` goes low and `chan_idx` holds its value until a `vid_strobe` falling edge resynchronises the sequence.
- R6: `clamp_en` follows `clamp_mode`: 00 passes `blk_strobe`; 01 passes `blk_strobe` AND `line_strobe`; 10 holds the clamp off; 11 passes `line_strobe`. The result appears three rising edges after the inputs change.
- R7: The first conversion after a synchronisation has `data_valid` low. A synchronisation is either a start from idle on a `vid_strobe` falling edge, or an entry into a single colour. `data_valid` is high on the cycles that follow while the block keeps running.
- R8: `alt_timing_eff` is high only when `alt_timing_req` is set and the colour field is 00. It updates one rising edge after either input changes.
- R9: While `rst` is high, the block clears `chan_idx` to 0 and drives `data_valid`, `clamp_en` and `alt_timing_eff` low. After `rst` is released, the block does not scan until a `vid_strobe` falling edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous digital reset, active high |
| blk_strobe | input | 1 | Black-level sample strobe, asynchronous |
| vid_strobe | input | 1 | Video sample strobe, asynchronous |
| line_strobe | input | 1 | Line clamp strobe, asynchronous |
| color_sel | input | 2 | 00 round-robin, 01 red, 10 green, 11 blue |
| clamp_mode | input | 2 | 00 pixel, 01 line, 10 none, 11 sample-and-hold line |
| alt_timing_req | input | 1 | Alternate video-strobe timing requested |
| chan_idx | output | 2 | Converter channel: 0 red, 1 green, 2 blue |
| clamp_en | output | 1 | Internal clamp enable |
| data_valid | output | 1 | Current conversion is usable |
| alt_timing_eff | output | 1 | Alternate timing in force |

## Verification
The bound checker covers the per-cycle rules. It checks that the index stays in range, that it steps correctly while running, that green is forced after a detected falling edge, and that a single colour is held. It also checks that validity drops on a start or a return from single-colour mode, that the clamp obeys the no-clamp and line-gating rules, and that alternate timing is masked outside round-robin mode. Some behaviours show only at the ports across whole scenarios, and the bench covers these. They are the end-to-end latency from an asynchronous strobe edge through the synchronisers, a realignment that lands where free rotation would have landed elsewhere, and the idle wait after reset or after leaving single-colour mode. The bench also walks every clamp-mode and strobe combination.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int NUM_CH = 3;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    typedef enum logic [1:0] {
        SEL_ALL = 2'b00,
        SEL_RED = 2'b01,
        SEL_GRN = 2'b10,
        SEL_BLU = 2'b11
    } color_sel_e;

    typedef enum logic [1:0] {
        CLMP_PIXEL   = 2'b00,
        CLMP_LINE    = 2'b01,
        CLMP_NONE    = 2'b10,
        CLMP_SH_LINE = 2'b11
    } clamp_mode_e;

    typedef struct packed {
        color_sel_e  color;
        clamp_mode_e clamp;
        logic        alt_timing;
    } scan_cfg_t;

    // strobe bundle order inside the synchroniser vector
    localparam int STB_BLK  = 0;
    localparam int STB_VID  = 1;
    localparam int STB_LINE = 2;
    localparam int STB_NUM  = 3;

    localparam scan_cfg_t CFG_RESET = '{color: SEL_ALL, clamp: CLMP_PIXEL, alt_timing: 1'b0};

    function automatic chan_e chan_step(chan_e cur);
        chan_e nxt;
        case (cur)
            CH_RED:  nxt = CH_GRN;
            CH_GRN:  nxt = CH_BLU;
            default: nxt = CH_RED;
        endcase
        return nxt;
    endfunction

    function automatic chan_e chan_of_sel(color_sel_e sel);
        chan_e c;
        case (sel)
            SEL_GRN: c = CH_GRN;
            SEL_BLU: c = CH_BLU;
            default: c = CH_RED;
        endcase
        return c;
    endfunction

    function automatic logic clamp_pick(clamp_mode_e mode, logic blk, logic line);
        logic en;
        case (mode)
            CLMP_PIXEL:   en = blk;
            CLMP_LINE:    en = blk & line;
            CLMP_SH_LINE: en = line;
            default:      en = 1'b0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] fall_out
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign sync_out = stage_q[STAGES-1];
    assign fall_out = prev_q & ~stage_q[STAGES-1];
endmodule

// File: rtl/channel_sequencer.sv
module channel_sequencer
    import scan_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  color_sel_e color,
    input  logic       vid_fall,
    output chan_e      chan_q,
    output logic       valid_q,
    output logic       run_q,
    output color_sel_e mode_prev_q
);
    logic  single_now;
    logic  enter_single;
    logic  leave_single;
    chan_e chan_d;
    logic  valid_d;
    logic  run_d;

    assign single_now   = (color != SEL_ALL);
    assign enter_single = single_now && (color != mode_prev_q);
    assign leave_single = !single_now && (mode_prev_q != SEL_ALL);

    always_comb begin
        chan_d  = chan_q;
        valid_d = 1'b0;
        run_d   = run_q;
        if (single_now) begin
            chan_d  = chan_of_sel(color);
            run_d   = 1'b1;
            valid_d = !enter_single;
        end else if (leave_single) begin
            run_d   = 1'b0;
        end else if (vid_fall) begin
            chan_d  = CH_GRN;
            run_d   = 1'b1;
            valid_d = run_q;
        end else if (run_q) begin
            chan_d  = chan_step(chan_q);
            valid_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q      <= CH_RED;
            valid_q     <= 1'b0;
            run_q       <= 1'b0;
            mode_prev_q <= SEL_ALL;
        end else begin
            chan_q      <= chan_d;
            valid_q     <= valid_d;
            run_q       <= run_d;
            mode_prev_q <= color;
        end
    end
endmodule

// File: rtl/clamp_ctrl.sv
module clamp_ctrl
    import scan_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  clamp_mode_e mode,
    input  logic        blk_s,
    input  logic        line_s,
    output logic        clamp_q
);
    always_ff @(posedge clk) begin
        if (rst) clamp_q <= 1'b0;
        else     clamp_q <= clamp_pick(mode, blk_s, line_s);
    end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            blk_strobe,
    input  logic            vid_strobe,
    input  logic            line_strobe,
    input  logic [1:0]      color_sel,
    input  logic [1:0]      clamp_mode,
    input  logic            alt_timing_req,
    output logic [CH_W-1:0] chan_idx,
    output logic            clamp_en,
    output logic            data_valid,
    output logic            alt_timing_eff
);
    scan_cfg_t          cfg_d;
    scan_cfg_t          cfg_q;
    logic [STB_NUM-1:0] stb_raw;
    logic [STB_NUM-1:0] stb_sync;
    logic [STB_NUM-1:0] stb_fall;
    chan_e              seq_chan;
    logic               seq_run;
    color_sel_e         seq_mode_prev;
    logic               vid_fall;
    logic               line_s;
    logic [1:0]         cfg_color;
    logic [1:0]         cfg_clamp;
    logic [1:0]         mode_prev_bits;

    always_comb begin
        cfg_d.color      = color_sel_e'(color_sel);
        cfg_d.clamp      = clamp_mode_e'(clamp_mode);
        cfg_d.alt_timing = alt_timing_req;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        stb_raw           = '0;
        stb_raw[STB_BLK]  = blk_strobe;
        stb_raw[STB_VID]  = vid_strobe;
        stb_raw[STB_LINE] = line_strobe;
    end

    strobe_sync #(
        .WIDTH  (STB_NUM),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (stb_raw),
        .sync_out (stb_sync),
        .fall_out (stb_fall)
    );

    assign vid_fall = stb_fall[STB_VID];
    assign line_s   = stb_sync[STB_LINE];

    channel_sequencer i_seq (
        .clk         (clk),
        .rst         (rst),
        .color       (cfg_q.color),
        .vid_fall    (vid_fall),
        .chan_q      (seq_chan),
        .valid_q     (data_valid),
        .run_q       (seq_run),
        .mode_prev_q (seq_mode_prev)
    );

    clamp_ctrl i_clamp (
        .clk     (clk),
        .rst     (rst),
        .mode    (cfg_q.clamp),
        .blk_s   (stb_sync[STB_BLK]),
        .line_s  (line_s),
        .clamp_q (clamp_en)
    );

    assign chan_idx       = seq_chan;
    assign alt_timing_eff = cfg_q.alt_timing && (cfg_q.color == SEL_ALL);

    assign cfg_color      = cfg_q.color;
    assign cfg_clamp      = cfg_q.clamp;
    assign mode_prev_bits = seq_mode_prev;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] color_q,
    input logic [1:0] mode_prev_q,
    input logic [1:0] clamp_q,
    input logic       run_q,
    input logic       vid_fall,
    input logic       line_s,
    input logic [1:0] chan_idx,
    input logic       data_valid,
    input logic       clamp_en,
    input logic       alt_timing_eff
);
    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
        chan_idx != 2'd3); // R1

    AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_q && color_q == 2'b00 && mode_prev_q == 2'b00 && !vid_fall)
        |=> chan_idx == (($past(chan_idx) == 2'd2) ? 2'd0 : $past(chan_idx) + 2'd1)); // R1

    AST_GREEN_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (color_q == 2'b00 && mode_prev_q == 2'b00 && vid_fall) |=> chan_idx == 2'd1); // R2

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (color_q != 2'b00) |=> chan_idx == $past(color_q) - 2'd1); // R3

    AST_RESYNC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (color_q == 2'b00 && mode_prev_q != 2'b00) |=> (!data_valid && $stable(chan_idx))); // R5

    AST_NO_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (clamp_q == 2'b10) |=> !clamp_en); // R6

    AST_LINE_GATE: assert property (@(posedge clk) disable iff (rst)
        ((clamp_q == 2'b01 || clamp_q == 2'b11) && !line_s) |=> !clamp_en); // R6

    AST_FIRST_DUMMY: assert property (@(posedge clk) disable iff (rst)
        (color_q == 2'b00 && mode_prev_q == 2'b00 && vid_fall && !run_q) |=> !data_valid); // R7

    AST_ALT_MASK: assert property (@(posedge clk) disable iff (rst)
        (color_q != 2'b00) |-> !alt_timing_eff); // R8
endmodule

bind scan_seq_top scan_seq_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .color_q        (cfg_color),
    .mode_prev_q    (mode_prev_bits),
    .clamp_q        (cfg_clamp),
    .run_q          (seq_run),
    .vid_fall       (vid_fall),
    .line_s         (line_s),
    .chan_idx       (chan_idx),
    .data_valid     (data_valid),
    .clamp_en       (clamp_en),
    .alt_timing_eff (alt_timing_eff)
);

// File: tb/test_scan_seq_top.sv
module test_scan_seq_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;
    localparam int  NVEC       = 16;

    // {clamp_mode[1:0], blk, line, expected clamp_en}
    localparam logic [4:0] CLAMP_VEC [NVEC] = '{
        5'b00_00_0, 5'b00_01_0, 5'b00_10_1, 5'b00_11_1,
        5'b01_00_0, 5'b01_01_0, 5'b01_10_0, 5'b01_11_1,
        5'b10_00_0, 5'b10_01_0, 5'b10_10_0, 5'b10_11_0,
        5'b11_00_0, 5'b11_01_1, 5'b11_10_0, 5'b11_11_1
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       blk_strobe, vid_strobe, line_strobe;
    logic [1:0] color_sel, clamp_mode;
    logic       alt_timing_req;
    logic [1:0] chan_idx;
    logic       clamp_en, data_valid, alt_timing_eff;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scan_seq_top i_scan_seq_top (
        .clk            (clk),
        .rst            (rst),
        .blk_strobe     (blk_strobe),
        .vid_strobe     (vid_strobe),
        .line_strobe    (line_strobe),
        .color_sel      (color_sel),
        .clamp_mode     (clamp_mode),
        .alt_timing_req (alt_timing_req),
        .chan_idx       (chan_idx),
        .clamp_en       (clamp_en),
        .data_valid     (data_valid),
        .alt_timing_eff (alt_timing_eff)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        report();
    end

    initial begin
        rst = 1'b1;
        blk_strobe = 1'b0; vid_strobe = 1'b1; line_strobe = 1'b0;
        color_sel = 2'b00; clamp_mode = 2'b00; alt_timing_req = 1'b1;
        tick(4);
        // R9: reset state, even with alternate timing requested
        check("R9", "chan_idx in reset", chan_idx, 0);
        check("R9", "data_valid in reset", data_valid, 0);
        check("R9", "clamp_en in reset", clamp_en, 0);
        check("R9", "alt_timing_eff in reset", alt_timing_eff, 0);
        rst = 1'b0;
        alt_timing_req = 1'b0;
        tick(6);
        check("R9", "no scanning before video edge", chan_idx, 0);
        check("R9", "no valid before video edge", data_valid, 0);

        // R6: clamp selection table
        for (int v = 0; v < NVEC; v++) begin
            clamp_mode  = CLAMP_VEC[v][4:3];
            blk_strobe  = CLAMP_VEC[v][2];
            line_strobe = CLAMP_VEC[v][1];
            tick(3);
            check("R6", $sformatf("clamp_en vector %0d", v), clamp_en, CLAMP_VEC[v][0]);
        end
        clamp_mode = 2'b00; blk_strobe = 1'b0; line_strobe = 1'b0;

        // R2 / R7: start from idle on a video falling edge
        vid_strobe = 1'b0;
        tick(3);
        check("R2", "green after start", chan_idx, 1);
        check("R7", "first conversion dummy", data_valid, 0);
        tick(1);
        check("R1", "green to blue", chan_idx, 2);
        check("R7", "valid after dummy", data_valid, 1);
        tick(1);
        check("R1", "blue to red", chan_idx, 0);
        tick(1);
        check("R1", "red to green", chan_idx, 1);

        // R2: realign where free rotation would give red
        vid_strobe = 1'b1;
        tick(2);
        check("R1", "rotation continues", chan_idx, 0);
        vid_strobe = 1'b0;
        tick(3);
        check("R2", "realigned to green", chan_idx, 1);
        check("R2", "realign keeps valid", data_valid, 1);
        tick(1);
        check("R2", "blue after realign", chan_idx, 2);

        // R8: alternate timing in round-robin mode
        alt_timing_req = 1'b1;
        tick(1);
        check("R8", "alt timing passes in round-robin", alt_timing_eff, 1);

        // R4 / R7: enter single blue
        color_sel = 2'b11;
        tick(1);
        check("R8", "alt timing masked in single", alt_timing_eff, 0);
        tick(1);
        check("R4", "blue tracked", chan_idx, 2);
        check("R7", "first single conversion dummy", data_valid, 0);
        tick(1);
        check("R7", "single valid afterwards", data_valid, 1);
        // R3: video edges ignored in single mode
        vid_strobe = 1'b1;
        tick(3);
        vid_strobe = 1'b0;
        tick(4);
        check("R3", "blue held through video edge", chan_idx, 2);
        color_sel = 2'b01;
        tick(2);
        check("R3", "red held", chan_idx, 0);
        color_sel = 2'b10;
        tick(3);
        check("R3", "green held", chan_idx, 1);
        color_sel = 2'b01;
        vid_strobe = 1'b1;
        tick(3);
        check("R3", "red before return", chan_idx, 0);

        // R5: back to round-robin, idle until resync
        color_sel = 2'b00;
        tick(2);
        check("R5", "valid drops on return", data_valid, 0);
        check("R8", "alt timing back in round-robin", alt_timing_eff, 1);
        tick(5);
        check("R5", "index frozen while idle", chan_idx, 0);
        check("R5", "still invalid while idle", data_valid, 0);
        vid_strobe = 1'b0;
        tick(3);
        check("R5", "resync to green", chan_idx, 1);
        check("R7", "dummy after resync", data_valid, 0);
        tick(1);
        check("R1", "blue after resync", chan_idx, 2);
        check("R7", "valid after resync", data_valid, 1);

        // R9: reset mid-run returns to idle waiting
        vid_strobe = 1'b1;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(6);
        check("R9", "index cleared and idle", chan_idx, 0);
        check("R9", "invalid after reset", data_valid, 0);

        report();
    end
endmodule